// File: doc/BRIEF.md
# Quad-SPI Nibble-to-Byte Packer

This block sits between a quad SPI link and a video line FIFO. It oversamples the serial clock, the active-low chip select and the four data lines in its own system clock, and takes one 4-bit nibble on each rising serial clock edge while the chip select is low. Every second nibble completes an 8-bit colour byte. The byte goes to the FIFO on a data bus with an active-low write strobe. The FIFO takes the value when the strobe returns high.

The design tracks which half of a byte it expects next. If pairing went wrong by one nibble, every later colour would be built from the tail of one byte and the head of the next. Deasserting the chip select always returns the tracker to the high-nibble position. An unpaired nibble left behind at that point raises a sticky flag, so a half-phase state cannot last until power is removed. If the FIFO reports full when a byte completes, the byte is discarded and a sticky overflow flag is raised.

Top module: `qspi_nibble_packer`

## Requirements
- R1: The first nibble of a byte lands in bits [7:4] of `fifo_data_o` and the second in bits [3:0]. Data lines are taken on the rising edge of `sck_i` (idle low) while `csn_i` is low.
- R2: If the rising `sck_i` edge that carries the second nibble is first sampled at system edge k, `fifo_wr_no` goes low after edge k+3.
- R3: `fifo_wr_no` stays low for exactly STROBE_LEN (default 2) system clocks and then returns high. `fifo_data_o` holds its value for at least one further clock after the release.
- R4: `fifo_data_o` does not change while `fifo_wr_no` is held low.
- R5: A rising `csn_i` returns the tracker to the high-nibble position, so the first nibble after the next select always starts a new byte.
- R6: A rising `csn_i` with one nibble unpaired sets `misalign_o`. The flag stays set until `err_clr_i` is high at a clock edge with no new misalignment in that same cycle.
- R7: `sck_i` edges while `csn_i` is high produce no nibble, no write and no change of phase.
- R8: A byte that completes while `fifo_full_i` is high, or while a strobe is still running, is discarded with no strobe and sets `overflow_o`. The flag stays set until it is cleared by `err_clr_i` in the same way as in R6.
- R9: After reset `fifo_wr_no` is high, `fifo_data_o` is 0, both flags are low and the tracker expects a high nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock from the link, asynchronous |
| csn_i | input | 1 | Chip select, active low, asynchronous |
| sd_i | input | 4 | Quad data lines, asynchronous |
| fifo_full_i | input | 1 | Downstream FIFO cannot accept a byte |
| err_clr_i | input | 1 | Clears both sticky flags |
| fifo_data_o | output | 8 | Colour byte to the FIFO |
| fifo_wr_no | output | 1 | Write strobe, active low; the FIFO captures on its rising edge |
| misalign_o | output | 1 | Sticky flag: a nibble was left unpaired at deselect |
| overflow_o | output | 1 | Sticky flag: a byte was discarded |

## Verification
The strobe for a byte falls three system clocks after the second nibble's serial edge is first sampled. It rises STROBE_LEN clocks later. Both flags change one clock after the synchronised event that causes them: the deselect edge for `misalign_o`, and the completed byte for `overflow_o`. The bench keeps a reference model that runs on the same rising edge and keeps the same pin history. It compares every output against that model on the falling edge of every cycle, so a result that arrives one clock early or late is reported. A separate byte scoreboard takes `fifo_data_o` at each release of the strobe and checks the nibble order and which bytes are discarded, without depending on cycle timing.

// File: rtl/qspi_pack_pkg.sv
package qspi_pack_pkg;
  typedef enum logic {
    PH_HI = 1'b0,
    PH_LO = 1'b1
  } phase_e;

  typedef enum logic [1:0] {
    WR_IDLE = 2'd0,
    WR_LOW  = 2'd1,
    WR_HOLD = 2'd2
  } wr_state_e;
endpackage

// File: rtl/qspi_pin_sync.sv
module qspi_pin_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/qspi_nibble_asm.sv
module qspi_nibble_asm
  import qspi_pack_pkg::*;
#(
  parameter int NIB_W  = 4,
  localparam int BYTE_W = 2 * NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_s_i,
  input  logic              csn_s_i,
  input  logic [NIB_W-1:0]  sd_s_i,
  input  logic              err_clr_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_vld_o,
  output logic              misalign_o
);
  logic             sck_d_q, csn_d_q;
  phase_e           phase_q;
  logic [NIB_W-1:0] hi_q;
  logic [BYTE_W-1:0] byte_q;
  logic             vld_q, mis_q;
  logic             sck_rise, cs_end, mis_set;

  // nibble strobe only while selected
  assign sck_rise = sck_s_i & ~sck_d_q & ~csn_s_i;
  assign cs_end   = csn_s_i & ~csn_d_q;
  assign mis_set  = cs_end & (phase_q == PH_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d_q <= 1'b0;
      csn_d_q <= 1'b1;
    end else begin
      sck_d_q <= sck_s_i;
      csn_d_q <= csn_s_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_HI;
      hi_q    <= '0;
      byte_q  <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (cs_end) begin
        phase_q <= PH_HI;
      end else if (sck_rise) begin
        if (phase_q == PH_HI) begin
          hi_q    <= sd_s_i;
          phase_q <= PH_LO;
        end else begin
          byte_q  <= {hi_q, sd_s_i};
          vld_q   <= 1'b1;
          phase_q <= PH_HI;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mis_q <= 1'b0;
    else if (mis_set)   mis_q <= 1'b1;
    else if (err_clr_i) mis_q <= 1'b0;
  end

  assign byte_o     = byte_q;
  assign byte_vld_o = vld_q;
  assign misalign_o = mis_q;
endmodule

// File: rtl/qspi_wr_strobe.sv
module qspi_wr_strobe
  import qspi_pack_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int STROBE_LEN = 2,
  localparam int CNT_W     = (STROBE_LEN < 2) ? 1 : $clog2(STROBE_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_vld_i,
  input  logic              fifo_full_i,
  input  logic              err_clr_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              wr_no,
  output logic              overflow_o
);
  wr_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] data_q;
  logic              wr_n_q, ovf_q;
  logic              accept, drop;

  assign accept = byte_vld_i & ~fifo_full_i & (state_q == WR_IDLE);
  assign drop   = byte_vld_i & ~accept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WR_IDLE;
      cnt_q   <= '0;
      data_q  <= '0;
      wr_n_q  <= 1'b1;
    end else begin
      unique case (state_q)
        WR_IDLE: if (accept) begin
          data_q  <= byte_i;
          wr_n_q  <= 1'b0;
          cnt_q   <= CNT_W'(STROBE_LEN - 1);
          state_q <= WR_LOW;
        end
        WR_LOW: if (cnt_q == '0) begin
          wr_n_q  <= 1'b1;
          state_q <= WR_HOLD;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
        // release cycle: bus held, no new load
        WR_HOLD: state_q <= WR_IDLE;
        default: state_q <= WR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (drop)      ovf_q <= 1'b1;
    else if (err_clr_i) ovf_q <= 1'b0;
  end

  assign data_o     = data_q;
  assign wr_no      = wr_n_q;
  assign overflow_o = ovf_q;
endmodule

// File: rtl/qspi_nibble_packer.sv
module qspi_nibble_packer #(
  parameter int NIB_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int STROBE_LEN  = 2,
  localparam int BYTE_W     = 2 * NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              csn_i,
  input  logic [NIB_W-1:0]  sd_i,
  input  logic              fifo_full_i,
  input  logic              err_clr_i,
  output logic [BYTE_W-1:0] fifo_data_o,
  output logic              fifo_wr_no,
  output logic              misalign_o,
  output logic              overflow_o
);
  logic              sck_s, csn_s;
  logic [NIB_W-1:0]  sd_s;
  logic [BYTE_W-1:0] asm_byte;
  logic              asm_vld;

  qspi_pin_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sck_i), .q_o(sck_s)
  );
  qspi_pin_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_csn (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(csn_i), .q_o(csn_s)
  );
  qspi_pin_sync #(.W(NIB_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_sd (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sd_i), .q_o(sd_s)
  );

  qspi_nibble_asm #(.NIB_W(NIB_W)) u_asm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sck_s_i    (sck_s),
    .csn_s_i    (csn_s),
    .sd_s_i     (sd_s),
    .err_clr_i  (err_clr_i),
    .byte_o     (asm_byte),
    .byte_vld_o (asm_vld),
    .misalign_o (misalign_o)
  );

  qspi_wr_strobe #(.BYTE_W(BYTE_W), .STROBE_LEN(STROBE_LEN)) u_wr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_i      (asm_byte),
    .byte_vld_i  (asm_vld),
    .fifo_full_i (fifo_full_i),
    .err_clr_i   (err_clr_i),
    .data_o      (fifo_data_o),
    .wr_no       (fifo_wr_no),
    .overflow_o  (overflow_o)
  );
endmodule

// File: rtl/qspi_nibble_packer_chk.sv
module qspi_nibble_packer_chk #(
  parameter int BYTE_W     = 8,
  parameter int STROBE_LEN = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fifo_full_i,
  input logic              err_clr_i,
  input logic [BYTE_W-1:0] fifo_data_o,
  input logic              fifo_wr_no,
  input logic              misalign_o,
  input logic              overflow_o
);
  int low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          low_cnt <= 0;
    else if (!fifo_wr_no) low_cnt <= low_cnt + 1;
    else                  low_cnt <= 0;
  end

  // R3
  low_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fifo_wr_no) |-> low_cnt == STROBE_LEN);

  // R3
  release_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fifo_wr_no) |=> $stable(fifo_data_o));

  // R4
  data_stable_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_wr_no && !$past(fifo_wr_no)) |-> $stable(fifo_data_o));

  // R8
  full_blocks_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fifo_wr_no) |-> !$past(fifo_full_i));

  // R6
  misalign_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (misalign_o && !err_clr_i) |=> misalign_o);

  // R8
  overflow_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && !err_clr_i) |=> overflow_o);
endmodule

bind qspi_nibble_packer qspi_nibble_packer_chk #(
  .BYTE_W(BYTE_W), .STROBE_LEN(STROBE_LEN)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fifo_full_i (fifo_full_i),
  .err_clr_i   (err_clr_i),
  .fifo_data_o (fifo_data_o),
  .fifo_wr_no  (fifo_wr_no),
  .misalign_o  (misalign_o),
  .overflow_o  (overflow_o)
);

// File: tb/qspi_nibble_packer_tb.sv
`timescale 1ns/1ps
module qspi_nibble_packer_tb;
  localparam int STROBE_LEN = 2;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b1;
  logic       sck = 1'b0, csn = 1'b1, full = 1'b0, clr = 1'b0;
  logic [3:0] sd = '0;
  logic [7:0] data;
  logic       wr_n, mis, ovf;

  int compared = 0, mismatched = 0;
  bit done = 0, model_on = 0;

  always #2.5 clk = ~clk;

  qspi_nibble_packer #(.STROBE_LEN(STROBE_LEN)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .csn_i(csn), .sd_i(sd),
    .fifo_full_i(full), .err_clr_i(clr), .fifo_data_o(data),
    .fifo_wr_no(wr_n), .misalign_o(mis), .overflow_o(ovf)
  );

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s act=%0h exp=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  // reference model: pin history plus behavioural state
  bit       h_sck[4], h_csn[4];
  bit [3:0] h_sd[4];
  bit       m_lo, m_vld, m_wr, m_mis, m_ovf;
  bit [3:0] m_hi;
  bit [7:0] m_byte, m_data;
  int       m_state, m_cnt;

  always @(posedge clk) begin
    bit acc, rise, cend, mset;
    if (!rst_ni) begin
      foreach (h_sck[i]) begin h_sck[i] = 0; h_csn[i] = 1; h_sd[i] = 0; end
      m_lo = 0; m_vld = 0; m_wr = 1; m_mis = 0; m_ovf = 0;
      m_hi = 0; m_byte = 0; m_data = 0; m_state = 0; m_cnt = 0;
      model_on = 1;
    end else begin
      acc = m_vld && !full && m_state == 0;
      if (m_vld && !acc) m_ovf = 1; else if (clr) m_ovf = 0;
      if (m_state == 0) begin
        if (acc) begin m_data = m_byte; m_wr = 0; m_cnt = STROBE_LEN - 1; m_state = 1; end
      end else if (m_state == 1) begin
        if (m_cnt == 0) begin m_wr = 1; m_state = 2; end else m_cnt--;
      end else m_state = 0;
      for (int i = 3; i > 0; i--) begin
        h_sck[i] = h_sck[i-1]; h_csn[i] = h_csn[i-1]; h_sd[i] = h_sd[i-1];
      end
      h_sck[0] = sck; h_csn[0] = csn; h_sd[0] = sd;
      rise = h_sck[2] && !h_sck[3] && !h_csn[2];
      cend = h_csn[2] && !h_csn[3];
      mset = cend && m_lo;
      m_vld = 0;
      if (cend) m_lo = 0;
      else if (rise) begin
        if (!m_lo) begin m_hi = h_sd[2]; m_lo = 1; end
        else begin m_byte = {m_hi, h_sd[2]}; m_vld = 1; m_lo = 0; end
      end
      if (mset) m_mis = 1; else if (clr) m_mis = 0;
    end
  end

  // per-cycle comparison and byte scoreboard
  bit [7:0] exp_q[$];
  bit       prev_wr = 1;
  always @(negedge clk) begin
    if (rst_ni && model_on && !done) begin
      chk("R2/R3 fifo_wr_no", wr_n, m_wr);
      chk("R1/R4 fifo_data_o", data, m_data);
      chk("R5/R6 misalign_o", mis, m_mis);
      chk("R8 overflow_o", ovf, m_ovf);
      if (!prev_wr && wr_n) begin
        if (exp_q.size() == 0) chk("R7/R8 unexpected write", 1, 0);
        else chk("R1 captured byte", data, exp_q.pop_front());
      end
      prev_wr = wr_n;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_nib(bit [3:0] n, int hp);
    sd = n; sck = 0; tick(hp);
    sck = 1; tick(hp);
    sck = 0;
  endtask

  task automatic send_byte(bit [7:0] b, int hp, bit expect_wr);
    send_nib(b[7:4], hp);
    send_nib(b[3:0], hp);
    if (expect_wr) exp_q.push_back(b);
  endtask

  task automatic cs_on();  csn = 0; tick(4); endtask
  task automatic cs_off(); csn = 1; tick(4); endtask

  task automatic pulse_clr();
    clr = 1; tick(1); clr = 0; tick(2);
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog act=running exp=finished");
      finish_run();
    end
  end

  initial begin
    #1 rst_ni = 0;
    tick(5);
    // R9 reset state
    chk("R9 wr_n reset", wr_n, 1);
    chk("R9 data reset", data, 0);
    chk("R9 flags reset", {mis, ovf}, 0);
    rst_ni = 1;
    tick(4);

    // R1 R2 R3 R4 normal stream at three serial rates
    cs_on();
    send_byte(8'hA5, 2, 1);
    send_byte(8'h3C, 2, 1);
    send_byte(8'hF0, 2, 1);
    send_byte(8'h81, 1, 1);
    send_byte(8'h7E, 1, 1);
    send_byte(8'h12, 3, 1);
    cs_off();
    tick(10);

    // R5 R6 odd nibble then reselect
    cs_on();
    send_byte(8'h55, 2, 1);
    send_nib(4'h9, 2);
    cs_off();
    tick(6);
    chk("R6 misalign set", mis, 1);
    cs_on();
    send_byte(8'hC3, 2, 1);
    cs_off();
    tick(8);
    chk("R6 misalign sticky", mis, 1);
    pulse_clr();
    chk("R6 misalign cleared", mis, 0);

    // R7 serial clock while deselected
    for (int i = 0; i < 6; i++) send_nib(4'(i + 3), 2);
    tick(8);
    chk("R7 no flag from idle clocks", {mis, ovf}, 0);
    cs_on();
    send_byte(8'h6B, 2, 1);
    cs_off();
    tick(10);

    // R8 full drops the byte
    full = 1;
    cs_on();
    send_byte(8'hEE, 2, 0);
    tick(8);
    full = 0;
    chk("R8 overflow set", ovf, 1);
    send_byte(8'h4D, 2, 1);
    cs_off();
    tick(10);
    chk("R8 overflow sticky", ovf, 1);
    pulse_clr();
    chk("R8 overflow cleared", ovf, 0);

    tick(20);
    chk("R1/R8 all expected bytes written", exp_q.size(), 0);
    finish_run();
  end
endmodule